// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel. It counts pulses of a clock-enable input and drives a single output line whose waveform depends on the selected operating mode. The count input is always enabled. Four modes are supported. Two are one-shot: an output that rises at terminal count, and an output that gives a one-cycle low strobe at terminal count. Two are periodic: a rate generator with one low cycle per period, and a square wave.

Software-style writes set up the channel. A mode write selects the waveform and sets the output to that mode's starting level. A reload write stores the count value and arms the counter. Counting starts on the first clock-enable after the reload write. A separate force input holds the output low. A system uses it when another timer source takes over the interrupt line that this output normally drives.

Top module: `timer_channel`

## Requirements
- R1: After reset the output is low and stays low, whatever clkEn does, until the channel is programmed.
- R2: modeSel codes are 0 (one-shot rising), 2 (rate generator), 3 (square wave) and 4 (one-shot strobe). A mode write with code 1, 5, 6 or 7 has no effect on the mode, the count or the output.
- R3: A valid mode write drives the output low for mode 0 and high for modes 2, 3 and 4 from the next cycle. A reload write stops any count in progress and returns the output to the current mode's starting level.
- R4: The reload value N is loaded into the counter on the first clkEn after the reload write. A clkEn in the write cycle itself does not count. Each later clkEn advances the count by one, and without clkEn nothing changes. A reload value of 0 means 2^WIDTH.
- R5: In mode 0 the output rises on the N-th clkEn after the loading clkEn and then stays high.
- R6: In mode 2 (N of 2 or more) the output repeats a period of N clkEns: high except for one clkEn-period low at the end of each period.
- R7: In mode 3 (N of 2 or more) the output is high for (N+1)/2 and low for N/2 clkEn-periods, rounding down, and repeats.
- R8: In mode 4 the output goes low on the N-th clkEn after the loading clkEn and returns high on the next one. This happens once.
- R9: While forceOff is high the output is low. Counting carries on unchanged, so on release the waveform continues as if no force had occurred.
- R10: A valid mode write and a reload write in the same cycle set the mode and arm the count together.
- R11: A valid mode write cancels a running or armed count. The output then holds the new starting level until a reload write is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Mode write strobe |
| modeSel | input | 3 | Mode code for a mode write |
| loadWe | input | 1 | Reload write strobe |
| loadVal | input | WIDTH | Reload value (0 means 2^WIDTH) |
| clkEn | input | 1 | Count enable pulse |
| forceOff | input | 1 | Forces the output low |
| timerOut | output | 1 | Timer output |

## Verification
Two writes can fall in the same cycle, and so can a write and a counting pulse. The bench provokes both. It issues a mode write and a reload write on the same edge, and it keeps clkEn high during every reload write. The first case must leave the channel armed in the new mode. The second must not count the write cycle, so every waveform is judged against a start one clkEn after the write. Sweeps over every reload value of a 4-bit channel, including the value 0, compare each sampled output level with a period computed arithmetically from the mode and N. Runs with a gated clkEn and a mid-count rewrite check the same timing under other input patterns.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Mode codes; the numeric values are the selection encoding on modeSel.
  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_RATE    = 3'd2,
    MODE_SQUARE  = 3'd3,
    MODE_STROBE  = 3'd4
  } timer_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // store a new reload value
    logic loadFull;  // count <= N
    logic loadHigh;  // count <= ceil(N/2)
    logic loadLow;   // count <= floor(N/2)
    logic decr;      // count <= count - 1
  } cnt_strobe_t;

  function automatic logic isValidMode(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd2) || (code == 3'd3) || (code == 3'd4);
  endfunction

  function automatic logic initLevel(input timer_mode_e mode);
    return (mode != MODE_ONESHOT);
  endfunction

endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strb,
  input  logic [WIDTH-1:0] loadVal,
  output logic             cntZero,
  output logic             cntOne,
  output logic             cntTwo
);

  localparam int CW = WIDTH + 1;
  localparam logic [CW-1:0] FULL_COUNT = {1'b1, {WIDTH{1'b0}}};

  logic [WIDTH-1:0] reloadQ;
  logic [CW-1:0]    countQ;
  logic [CW-1:0]    effVal;

  // A stored zero stands for the full 2^WIDTH range.
  assign effVal = (reloadQ == '0) ? FULL_COUNT : {1'b0, reloadQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strb.capture) begin
      reloadQ <= loadVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.loadFull) begin
      countQ <= effVal;
    end else if (strb.loadHigh) begin
      countQ <= (effVal + CW'(1)) >> 1;
    end else if (strb.loadLow) begin
      countQ <= effVal >> 1;
    end else if (strb.decr) begin
      countQ <= countQ - CW'(1);
    end
  end

  assign cntZero = (countQ == CW'(0));
  assign cntOne  = (countQ == CW'(1));
  assign cntTwo  = (countQ == CW'(2));

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWe,
  input  logic [2:0]  modeSel,
  input  logic        loadWe,
  input  logic        clkEn,
  input  logic        cntZero,
  input  logic        cntOne,
  input  logic        cntTwo,
  output cnt_strobe_t strb,
  output logic        outLevel
);

  timer_mode_e modeQ, modeD;
  logic pendQ, pendD;
  logic runQ, runD;
  logic outQ, outD;

  always_comb begin
    strb  = '0;
    modeD = modeQ;
    pendD = pendQ;
    runD  = runQ;
    outD  = outQ;
    if (ctrlWe && isValidMode(modeSel)) begin
      modeD        = timer_mode_e'(modeSel);
      runD         = 1'b0;
      pendD        = loadWe;
      strb.capture = loadWe;
      outD         = initLevel(modeD);
    end else if (loadWe) begin
      strb.capture = 1'b1;
      pendD        = 1'b1;
      runD         = 1'b0;
      outD         = initLevel(modeQ);
    end else if (clkEn && pendQ) begin
      pendD = 1'b0;
      runD  = 1'b1;
      if (modeQ == MODE_SQUARE) strb.loadHigh = 1'b1;
      else                      strb.loadFull = 1'b1;
    end else if (clkEn && runQ) begin
      case (modeQ)
        MODE_ONESHOT: begin
          if (cntOne) begin
            outD = 1'b1;
            runD = 1'b0;
          end else begin
            strb.decr = 1'b1;
          end
        end
        MODE_STROBE: begin
          if (cntZero) begin
            outD = 1'b1;
            runD = 1'b0;
          end else begin
            strb.decr = 1'b1;
            if (cntOne) outD = 1'b0;
          end
        end
        MODE_RATE: begin
          if (cntOne) begin
            strb.loadFull = 1'b1;
            outD          = 1'b1;
          end else begin
            strb.decr = 1'b1;
            outD      = !cntTwo;
          end
        end
        MODE_SQUARE: begin
          if (cntOne) begin
            outD = !outQ;
            if (outQ) strb.loadLow  = 1'b1;
            else      strb.loadHigh = 1'b1;
          end else begin
            strb.decr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_ONESHOT;
      pendQ <= 1'b0;
      runQ  <= 1'b0;
      outQ  <= 1'b0;
    end else begin
      modeQ <= modeD;
      pendQ <= pendD;
      runQ  <= runD;
      outQ  <= outD;
    end
  end

  assign outLevel = outQ;

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [2:0]       modeSel,
  input  logic             loadWe,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             clkEn,
  input  logic             forceOff,
  output logic             timerOut
);

  cnt_strobe_t strb;
  logic cntZero, cntOne, cntTwo;
  logic outLevel;

  timer_ctrl ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .modeSel  (modeSel),
    .loadWe   (loadWe),
    .clkEn    (clkEn),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .cntTwo   (cntTwo),
    .strb     (strb),
    .outLevel (outLevel)
  );

  timer_datapath #(.WIDTH(WIDTH)) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadVal (loadVal),
    .cntZero (cntZero),
    .cntOne  (cntOne),
    .cntTwo  (cntTwo)
  );

  // The force input masks the output only; counting keeps going.
  assign timerOut = outLevel & ~forceOff;

endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk
  import timer_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWe,
  input logic [2:0] modeSel,
  input logic       loadWe,
  input logic       clkEn,
  input logic       forceOff,
  input logic       timerOut
);

  logic [2:0] trkMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trkMode <= 3'd0;
    else if (ctrlWe && isValidMode(modeSel)) trkMode <= modeSel;
  end

  // R3
  mode0_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && modeSel == 3'd0) |=> !timerOut);

  // R3
  high_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && (modeSel == 3'd2 || modeSel == 3'd3 || modeSel == 3'd4))
      |=> (timerOut || forceOff));

  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trkMode == 3'd0 && timerOut && !ctrlWe && !loadWe) |=> (timerOut || forceOff));

  // R6, R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((trkMode == 3'd2 || trkMode == 3'd4) && !timerOut && !forceOff && clkEn
      && !ctrlWe && !loadWe) |=> (timerOut || forceOff));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !ctrlWe && !loadWe && !forceOff) |=> ($stable(timerOut) || forceOff));

endmodule

bind timer_channel timer_channel_chk chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlWe   (ctrlWe),
  .modeSel  (modeSel),
  .loadWe   (loadWe),
  .clkEn    (clkEn),
  .forceOff (forceOff),
  .timerOut (timerOut)
);

// File: tb/timer_channel_test.sv
`timescale 1ns/1ps
module timer_channel_test;

  localparam int W    = 4;
  localparam int FULL = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic loadWe = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic clkEn = 1'b1;
  logic forceOff = 1'b0;
  logic timerOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  timer_channel #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .modeSel(modeSel),
    .loadWe(loadWe), .loadVal(loadVal), .clkEn(clkEn),
    .forceOff(forceOff), .timerOut(timerOut)
  );

  always #2 clk = ~clk;

  function automatic int effOf(input int n);
    return (n == 0) ? FULL : n;
  endfunction

  // Output level after the t-th clkEn following the loading clkEn (t=0 is the loading one).
  function automatic bit expOut(input int mode, input int eff, input int t);
    case (mode)
      0: return t >= eff;
      4: return t != eff;
      2: return (t % eff) != (eff - 1);
      3: return (t % eff) < ((eff + 1) / 2);
      default: return 1'b0;
    endcase
  endfunction

  task automatic stepCheck(input bit exp, input string req);
    @(negedge clk);
    nChecks++;
    if (timerOut !== exp) begin
      nFail++;
      $display("FAIL %s: timerOut=%b expected %b at %0t", req, timerOut, exp, $time);
    end
  endtask

  task automatic progMode(input int mode, input string req);
    modeSel = 3'(mode); ctrlWe = 1'b1;
    stepCheck(mode != 0, req);
    ctrlWe = 1'b0;
  endtask

  task automatic reload(input int mode, input int n, input string req);
    loadVal = W'(n); loadWe = 1'b1;
    stepCheck(mode != 0, req);
    loadWe = 1'b0;
  endtask

  task automatic armRun(input int mode, input int n, input int cycles, input string req);
    progMode(mode, "R3");
    reload(mode, n, "R3");
    for (int t = 0; t < cycles; t++) stepCheck(expOut(mode, effOf(n), t), req);
  endtask

  task automatic gatedRun(input int mode, input int n, input int gap, input int iters);
    int e;
    progMode(mode, "R3");
    reload(mode, n, "R4");   // clkEn is high in the write cycle and must not count
    e = 0;
    for (int i = 0; i < iters; i++) begin
      clkEn = ((i % gap) == 1);
      if (clkEn) e++;
      stepCheck((e == 0) ? (mode != 0) : expOut(mode, effOf(n), e - 1), "R4");
    end
    clkEn = 1'b1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    nChecks++;
    if (timerOut !== 1'b0) begin
      nFail++;
      $display("FAIL R1: timerOut=%b expected 0 in reset", timerOut);
    end
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) stepCheck(1'b0, "R1");

    // R5, R8: one-shot sweeps over all reload values, 0 meaning 16 (R4)
    for (int n = 0; n < FULL; n++) armRun(0, n, effOf(n) + 4, "R5");
    for (int n = 0; n < FULL; n++) armRun(4, n, effOf(n) + 4, "R8");
    // R6, R7: periodic sweeps, N from 2 to 16
    for (int k = 2; k <= FULL; k++) armRun(2, k % FULL, 2 * k + 2, "R6");
    for (int k = 2; k <= FULL; k++) armRun(3, k % FULL, 2 * k + 2, "R7");

    // R2: invalid mode codes during a rate-generator run change nothing
    progMode(2, "R3");
    reload(2, 5, "R3");
    for (int t = 0; t < 16; t++) begin
      if (t >= 3 && t <= 6) begin
        ctrlWe = 1'b1;
        case (t)
          3: modeSel = 3'd1;
          4: modeSel = 3'd5;
          5: modeSel = 3'd6;
          default: modeSel = 3'd7;
        endcase
      end else begin
        ctrlWe = 1'b0;
      end
      stepCheck(expOut(2, 5, t), "R2");
    end
    ctrlWe = 1'b0;

    // R3, R4: reload mid-count restores start level and restarts
    progMode(3, "R3");
    reload(3, 4, "R3");
    for (int t = 0; t < 3; t++) stepCheck(expOut(3, 4, t), "R7");
    reload(3, 5, "R3");
    for (int t = 0; t < 12; t++) stepCheck(expOut(3, 5, t), "R4");
    progMode(0, "R3");
    reload(0, 9, "R3");
    for (int t = 0; t < 4; t++) stepCheck(expOut(0, 9, t), "R5");
    reload(0, 3, "R3");
    for (int t = 0; t < 7; t++) stepCheck(expOut(0, 3, t), "R4");

    // R11: mode write cancels the count
    progMode(3, "R3");
    reload(3, 4, "R3");
    for (int t = 0; t < 3; t++) stepCheck(expOut(3, 4, t), "R7");
    progMode(4, "R11");
    for (int i = 0; i < 20; i++) stepCheck(1'b1, "R11");
    progMode(0, "R11");
    for (int i = 0; i < 20; i++) stepCheck(1'b0, "R11");
    reload(0, 2, "R11");
    for (int t = 0; t < 5; t++) stepCheck(expOut(0, 2, t), "R11");

    // R9: force low in the middle of a square wave
    progMode(3, "R3");
    reload(3, 6, "R3");
    for (int t = 0; t < 24; t++) begin
      forceOff = (t >= 5 && t <= 9);
      stepCheck(forceOff ? 1'b0 : expOut(3, 6, t), "R9");
    end
    forceOff = 1'b0;

    // R10: mode write and reload on the same edge
    modeSel = 3'd4; ctrlWe = 1'b1; loadVal = W'(2); loadWe = 1'b1;
    stepCheck(1'b1, "R10");
    ctrlWe = 1'b0; loadWe = 1'b0;
    for (int t = 0; t < 6; t++) stepCheck(expOut(4, 2, t), "R10");
    modeSel = 3'd0; ctrlWe = 1'b1; loadVal = W'(3); loadWe = 1'b1;
    stepCheck(1'b0, "R10");
    ctrlWe = 1'b0; loadWe = 1'b0;
    for (int t = 0; t < 6; t++) stepCheck(expOut(0, 3, t), "R10");

    // R4: gated count enable
    gatedRun(2, 3, 3, 30);
    gatedRun(3, 5, 2, 30);
    gatedRun(0, 4, 4, 24);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule